// File: doc/BRIEF.md
# Sleep-State Wake-Up Detector for a Single-Wire Bus Transceiver

This block runs while the transceiver is asleep. It looks for two kinds of wake-up and, when either one is found, sends a one-clock request to the mode controller. The mode controller then moves to the Awake state, where the inhibit output goes high and the receive output is pulled low. Both inputs arrive already reduced to logic levels.

The first kind of wake-up is remote. It comes from the bus as one complete dominant pulse. The pulse must start from recessive, stay dominant for longer than the bus filter time, and then return to recessive. The second kind is local. It comes from a wake pin that wakes on a change in either direction. The reference for that change is the pin level latched at the moment Sleep began, and the new level must then hold for the pin filter time. Both filter times are counted in clock cycles. They are derived from a cycles-per-microsecond input, so the same netlist works at any clock rate. Both raw inputs pass through two-flop synchronizers before they are filtered.

Top module: `lin_wake_detect`

## Requirements
- R1: After reset, wake_req_o is low.
- R2: No wake request is issued while sleep_i is low, whatever the bus and pin do.
- R3: The bus encoding is bus_i = 1 for recessive and bus_i = 0 for dominant. In Sleep, a bus wake request is issued once for a recessive-to-dominant edge, then more than cycles_per_us_i × BUS_FILT_US consecutive dominant cycles, then a return to recessive. BUS_FILT_US defaults to 70, and cycles_per_us_i must be at least 1.
- R4: A dominant pulse of cycles_per_us_i × BUS_FILT_US cycles or fewer is ignored. The count restarts on every pulse, so short pulses never add up.
- R5: A qualified dominant level that is still held does not wake. The request follows only the return to recessive.
- R6: If the bus is dominant when Sleep begins, that dominant period never wakes, however long it lasts. A recessive level must be seen first, and a later qualified pulse then wakes.
- R7: The wake_pin_i level in the cycle Sleep begins is stored as the reference. Holding the pin at that level never wakes.
- R8: A wake_pin_i level opposite to the reference, held for cycles_per_us_i × PIN_FILT_US consecutive cycles, issues a wake request. PIN_FILT_US defaults to 40. This works for both rising and falling changes, and a shorter excursion is ignored.
- R9: wake_req_o is a single-cycle pulse. At most one request is issued per Sleep period, until sleep_i falls and rises again.
- R10: When sleep_i falls, all filter progress is discarded. A dominant period that spans an exit and re-entry does not wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | High while the transceiver is in Sleep; its rising edge marks Sleep entry |
| cycles_per_us_i | input | CPU_W | Clock cycles per microsecond, used to scale both filter times |
| bus_i | input | 1 | Digitized bus level, 1 = recessive, 0 = dominant (asynchronous) |
| wake_pin_i | input | 1 | Digitized wake pin level (asynchronous) |
| wake_req_o | output | 1 | One-cycle wake request to the mode controller |

## Verification
The bench goes after the exact filter boundaries on both paths: the pulse one cycle too short and the pulse just long enough. A design with an off-by-one counter would wake one cycle early or miss the minimum pulse. It holds the bus dominant across Sleep entry and across a Sleep exit and re-entry. A design that skips the recessive precondition, or keeps its count across the exit, would raise a false wake after a bus short. It drives the wake pin in both directions from both reference levels, and it also holds the pin at its entry level. A design that latches the reference at the wrong time, or detects only one polarity, would wake falsely or stay asleep. It combines bus and pin events in one Sleep period to catch a design that repeats or stretches the request.

// File: rtl/lin_wake_pkg.sv
package lin_wake_pkg;
  typedef enum logic [1:0] {
    BUS_WAIT_REC,
    BUS_IDLE,
    BUS_TIMING,
    BUS_QUAL
  } bus_st_e;
endpackage

// File: rtl/lwd_sync.sv
module lwd_sync #(
  parameter int unsigned WIDTH = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(STAGES); s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lwd_bus_filter.sv
module lwd_bus_filter
  import lin_wake_pkg::*;
#(
  parameter int unsigned TMR_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             rec_i,
  input  logic [TMR_W-1:0] thr_i,
  output logic             fire_o
);
  bus_st_e          st_q;
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BUS_WAIT_REC;
      cnt_q <= '0;
    end else if (clear_i) begin
      st_q  <= BUS_WAIT_REC;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        BUS_WAIT_REC: if (rec_i) st_q <= BUS_IDLE;
        BUS_IDLE: begin
          if (!rec_i) begin
            st_q  <= BUS_TIMING;
            cnt_q <= TMR_W'(1);
          end
        end
        BUS_TIMING: begin
          if (rec_i) begin
            st_q  <= BUS_IDLE;
            cnt_q <= '0;
          end else if (cnt_q == thr_i) begin
            st_q  <= BUS_QUAL;
          end else begin
            cnt_q <= cnt_q + TMR_W'(1);
          end
        end
        BUS_QUAL: begin
          if (rec_i) begin
            st_q  <= BUS_IDLE;
            cnt_q <= '0;
          end
        end
        default: st_q <= BUS_WAIT_REC;
      endcase
    end
  end

  // qualified pulse ends on the recessive edge
  assign fire_o = !clear_i && (st_q == BUS_QUAL) && rec_i;
endmodule

// File: rtl/lwd_pin_filter.sv
module lwd_pin_filter #(
  parameter int unsigned TMR_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             capture_i,
  input  logic             level_i,
  input  logic [TMR_W-1:0] thr_i,
  output logic             ref_o,
  output logic             fire_o
);
  logic             ref_q;
  logic [TMR_W-1:0] cnt_q;
  logic             diff;

  assign diff = level_i ^ ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ref_q <= 1'b0;
    else if (capture_i) ref_q <= level_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clear_i || !diff) cnt_q <= '0;
    else if (cnt_q < thr_i)  cnt_q <= cnt_q + TMR_W'(1);
  end

  assign ref_o  = ref_q;
  assign fire_o = !clear_i && diff && (cnt_q == thr_i - TMR_W'(1));
endmodule

// File: rtl/lin_wake_detect.sv
module lin_wake_detect #(
  parameter int unsigned CPU_W       = 8,
  parameter int unsigned BUS_FILT_US = 70,
  parameter int unsigned PIN_FILT_US = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_i,
  input  logic [CPU_W-1:0] cycles_per_us_i,
  input  logic             bus_i,
  input  logic             wake_pin_i,
  output logic             wake_req_o
);
  localparam int unsigned MAX_US = (BUS_FILT_US > PIN_FILT_US) ? BUS_FILT_US : PIN_FILT_US;
  localparam int unsigned TMR_W  = CPU_W + $clog2(MAX_US + 1);

  logic [1:0]       sync_q;
  logic             bus_rec_s, pin_s;
  logic             sleep_q, enter, active;
  logic [TMR_W-1:0] bus_thr, pin_thr;
  logic             bus_fire, pin_fire, pin_ref;
  logic             fired_q, wake_set;

  lwd_sync #(.WIDTH(2), .STAGES(2), .RST_VAL(2'b01)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({wake_pin_i, bus_i}),
    .q_o   (sync_q)
  );
  assign bus_rec_s = sync_q[0];
  assign pin_s     = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sleep_q <= 1'b0;
    else         sleep_q <= sleep_i;
  end
  assign enter  = sleep_i & ~sleep_q;
  assign active = sleep_i & sleep_q;

  assign bus_thr = TMR_W'(cycles_per_us_i) * TMR_W'(BUS_FILT_US);
  assign pin_thr = TMR_W'(cycles_per_us_i) * TMR_W'(PIN_FILT_US);

  lwd_bus_filter #(.TMR_W(TMR_W)) u_bus (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(~active),
    .rec_i  (bus_rec_s),
    .thr_i  (bus_thr),
    .fire_o (bus_fire)
  );

  lwd_pin_filter #(.TMR_W(TMR_W)) u_pin (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (~active),
    .capture_i(enter),
    .level_i  (pin_s),
    .thr_i    (pin_thr),
    .ref_o    (pin_ref),
    .fire_o   (pin_fire)
  );

  // one request per sleep period
  assign wake_set = active & ~fired_q & (bus_fire | pin_fire);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fired_q    <= 1'b0;
      wake_req_o <= 1'b0;
    end else begin
      wake_req_o <= wake_set;
      if (!sleep_i)      fired_q <= 1'b0;
      else if (wake_set) fired_q <= 1'b1;
    end
  end
endmodule

// File: rtl/lwd_chk.sv
module lwd_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sleep_i,
  input logic wake_req_o,
  input logic bus_fire_i,
  input logic bus_rec_i,
  input logic pin_fire_i,
  input logic pin_lvl_i,
  input logic pin_ref_i
);
  // R9
  wake_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req_o |=> !wake_req_o);

  // R2
  wake_in_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req_o |-> ($past(sleep_i) && $past(sleep_i, 2)));

  // R3
  bus_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_fire_i |-> (bus_rec_i && !$past(bus_rec_i)));

  // R7
  pin_ref_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && $past(sleep_i) && $past(sleep_i, 2)) |-> $stable(pin_ref_i));

  // R8
  pin_fire_diff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_fire_i |-> (pin_lvl_i != pin_ref_i));
endmodule

bind lin_wake_detect lwd_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sleep_i   (sleep_i),
  .wake_req_o(wake_req_o),
  .bus_fire_i(bus_fire),
  .bus_rec_i (bus_rec_s),
  .pin_fire_i(pin_fire),
  .pin_lvl_i (pin_s),
  .pin_ref_i (pin_ref)
);

// File: tb/sim_lin_wake_detect.sv
module sim_lin_wake_detect;
  localparam int BUS_US = 70;
  localparam int PIN_US = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep = 1'b0;
  logic [7:0] cpu = 8'd2;
  logic       bus = 1'b1;
  logic       pin = 1'b0;
  logic       wake_req;

  int checks = 0;
  int errors = 0;
  int wake_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lin_wake_detect u0 (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .sleep_i        (sleep),
    .cycles_per_us_i(cpu),
    .bus_i          (bus),
    .wake_pin_i     (pin),
    .wake_req_o     (wake_req)
  );

  always @(negedge clk) if (rst_n && wake_req) wake_cnt++;

  function automatic int bus_thr();
    return int'(cpu) * BUS_US;
  endfunction
  function automatic int pin_thr();
    return int'(cpu) * PIN_US;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic enter_sleep(input logic pin_lvl, input logic bus_lvl);
    sleep = 1'b0; pin = pin_lvl; bus = bus_lvl;
    tick(6);
    wake_cnt = 0;
    sleep = 1'b1;
    tick(4);
  endtask

  task automatic leave_sleep();
    tick(8);
    sleep = 1'b0;
    tick(4);
  endtask

  task automatic dom_pulse(input int len, input int gap);
    bus = 1'b0; tick(len);
    bus = 1'b1; tick(gap);
  endtask

  task automatic pin_pulse(input logic ref_lvl, input int len, input int gap);
    pin = ~ref_lvl; tick(len);
    pin = ref_lvl;  tick(gap);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    tick(3);
    // R1
    check("R1 reset", int'(wake_req), 0);
    rst_n = 1'b1;
    tick(3);
    check("R1 after release", int'(wake_req), 0);

    // R2: activity outside sleep
    cpu = 8'd2; wake_cnt = 0;
    dom_pulse(3 * bus_thr(), 5);
    pin = 1'b1; tick(3 * pin_thr()); pin = 1'b0; tick(3 * pin_thr());
    tick(8);
    check("R2 no wake while awake", wake_cnt, 0);

    // R4 / R3 boundary at thr and thr+1
    enter_sleep(1'b0, 1'b1);
    dom_pulse(bus_thr(), 6);
    tick(8);
    check("R4 pulse equal to filter", wake_cnt, 0);
    dom_pulse(bus_thr() + 1, 6);
    leave_sleep();
    check("R3 pulse one longer", wake_cnt, 1);

    // R4: short pulses do not add up
    enter_sleep(1'b0, 1'b1);
    dom_pulse(100, 2); dom_pulse(100, 2); dom_pulse(100, 6);
    leave_sleep();
    check("R4 short pulses", wake_cnt, 0);

    // R5: held dominant, release wakes
    enter_sleep(1'b0, 1'b1);
    bus = 1'b0; tick(3 * bus_thr());
    check("R5 held dominant", wake_cnt, 0);
    bus = 1'b1;
    leave_sleep();
    check("R5 release", wake_cnt, 1);

    // R6: dominant at entry
    enter_sleep(1'b0, 1'b0);
    tick(2 * bus_thr()); bus = 1'b1; tick(10);
    check("R6 dominant at entry", wake_cnt, 0);
    dom_pulse(bus_thr() + 20, 6);
    leave_sleep();
    check("R6 later pulse", wake_cnt, 1);

    // R10: dominant spanning exit and re-entry
    enter_sleep(1'b0, 1'b1);
    bus = 1'b0; tick(100);
    sleep = 1'b0; tick(4); sleep = 1'b1;
    tick(100); bus = 1'b1;
    leave_sleep();
    check("R10 exit discards progress", wake_cnt, 0);

    // R8: pin boundary, rising
    enter_sleep(1'b0, 1'b1);
    pin_pulse(1'b0, pin_thr() - 1, 6);
    tick(8);
    check("R8 pin one short", wake_cnt, 0);
    pin_pulse(1'b0, pin_thr(), 6);
    leave_sleep();
    check("R8 pin rising", wake_cnt, 1);

    // R8: falling from reference 1
    enter_sleep(1'b1, 1'b1);
    pin_pulse(1'b1, pin_thr(), 6);
    leave_sleep();
    check("R8 pin falling", wake_cnt, 1);

    // R7: holding reference never wakes
    enter_sleep(1'b1, 1'b1);
    tick(3 * pin_thr());
    check("R7 held high ref", wake_cnt, 0);
    sleep = 1'b0; tick(4);
    enter_sleep(1'b0, 1'b1);
    tick(3 * pin_thr());
    check("R7 held low ref", wake_cnt, 0);
    pin = 1'b1; tick(pin_thr() + 4);
    leave_sleep();
    check("R7 change from ref", wake_cnt, 1);

    // R9: one request per sleep period
    enter_sleep(1'b0, 1'b1);
    dom_pulse(bus_thr() + 5, 6);
    pin_pulse(1'b0, pin_thr() + 5, 6);
    dom_pulse(bus_thr() + 5, 6);
    leave_sleep();
    check("R9 single per period", wake_cnt, 1);
    enter_sleep(1'b0, 1'b1);
    pin_pulse(1'b0, pin_thr() + 5, 6);
    leave_sleep();
    check("R9 re-armed", wake_cnt, 1);

    // R3 / R4 at a realistic clock rate
    cpu = 8'd50;
    enter_sleep(1'b0, 1'b1);
    dom_pulse(bus_thr(), 6);
    tick(8);
    check("R4 full rate equal", wake_cnt, 0);
    dom_pulse(bus_thr() + 1, 6);
    leave_sleep();
    check("R3 full rate longer", wake_cnt, 1);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int exp_w, n, len;
      logic r;
      cpu = 8'($urandom_range(3, 1));
      exp_w = 0;
      if ($urandom_range(1, 0) == 1) begin
        if ($urandom_range(3, 0) == 0) begin
          enter_sleep(1'b0, 1'b0);
          tick($urandom_range(2 * bus_thr(), 1));
          bus = 1'b1; tick(3);
        end else begin
          enter_sleep(1'b0, 1'b1);
        end
        n = $urandom_range(3, 1);
        for (int k = 0; k < n; k++) begin
          len = bus_thr() - 2 + $urandom_range(4, 0);
          if (len > bus_thr()) exp_w = 1;
          dom_pulse(len, $urandom_range(6, 2));
        end
        leave_sleep();
        check("R3 R4 random bus", wake_cnt, exp_w);
      end else begin
        r = 1'($urandom_range(1, 0));
        enter_sleep(r, 1'b1);
        n = $urandom_range(3, 1);
        for (int k = 0; k < n; k++) begin
          len = pin_thr() - 2 + $urandom_range(4, 0);
          if (len >= pin_thr()) exp_w = 1;
          pin_pulse(r, len, $urandom_range(6, 2));
        end
        leave_sleep();
        check("R8 random pin", wake_cnt, exp_w);
      end
    end

    done = 1;
    summary();
  end
endmodule